// File: doc/BRIEF.md
# Multi-format synchronous serial port

This block is a master-mode synchronous serial port. It exchanges words of 4 to 16 bits with one peripheral. A single sequencer serves three frame formats: SPI with an active-low select, a frame-pulse format, and a three-wire command/response format in which an 8-bit command is followed by a turnaround bit and a read. Software writes one control word that sets the enable, the clock source, the format, the word size and the clock-rate divider.

Transmit words go into a small transmit FIFO, right-justified. Received words come out of a small receive FIFO, right-justified and zero-filled. Both FIFOs use plain push/pop ports. The serial clock is derived from either the block clock or a slow external clock input. A transfer begins as soon as a transmit word is waiting and the receive FIFO has room.

Top module: `multi_serial_port`

## Requirements
- R1: The size field `cfgWdata[7:4]` holds code C, and the word length is C+1 bits, so code 3 gives 4 bits and code 15 gives 16 bits. In SPI format each word produces exactly C+1 rising edges of `sclk`.
- R2: Size codes 0, 1 and 2 are invalid. While one of them is set, `sclk` stays low, no word leaves the transmit FIFO, and nothing is received.
- R3: Only the low C+1 bits of a transmit word are sent, most significant of them first. Each received word is stored right-justified with every bit above bit C at zero.
- R4: Format code 00 (`cfgWdata[3:2]`) is SPI. `frm` is high while idle and low for exactly (C+1)·2·(D+1) clock cycles per word, where D is the divider. `sclk` idles low. Data changes while `sclk` is low and is sampled on the rising edge.
- R5: Format code 01 is frame-pulse. `frm` idles low and is high for exactly one bit period just before the MSB. Each word gives C+2 rising edges of `sclk`. Queued words follow one another with a single idle clock between them.
- R6: Format code 10 is command/response. While `frm` is low, the low 8 bits of the transmit word are sent MSB first. One turnaround bit follows, and then C+1 bits are read from `rxd`. That is C+10 rising edges, and `frm` is low for (C+10)·2·(D+1) cycles.
- R7: Format code 11 is invalid. It holds the port idle just as R2 does.
- R8: Bit 1 of the control word selects the clock source: 0 for `clk`, 1 for rising edges of `extClk`. Successive rising edges of `sclk` are 2·(D+1) source periods apart, where D = `cfgWdata[15:8]` and ranges from 0 to 255.
- R9: Bit 0 of the control word is the enable. While it is 0, no transfer takes place. After reset the control word on `cfgRdata` reads all zero.
- R10: A word starts only when the transmit FIFO is not empty and the receive FIFO is not full. Every finished word pushes exactly one receive entry.
- R11: Each FIFO holds 4 words. A push to a full FIFO is dropped, a pop from an empty FIFO is ignored, and order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock and internal serial clock source |
| rstN | input | 1 | Active-low reset |
| cfgWe | input | 1 | Write strobe for the control word |
| cfgWdata | input | 16 | Control word: divider, size code, format, source, enable |
| cfgRdata | output | 16 | Current control word |
| txPush | input | 1 | Push `txData` into the transmit FIFO |
| txData | input | 16 | Right-justified transmit word or command |
| txFull | output | 1 | Transmit FIFO full |
| rxPop | input | 1 | Pop the head of the receive FIFO |
| rxData | output | 16 | Head of the receive FIFO |
| rxEmpty | output | 1 | Receive FIFO empty |
| extClk | input | 1 | External serial clock source |
| sclk | output | 1 | Serial clock |
| frm | output | 1 | Select or frame pulse, depending on format |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |

## Verification
The bit counter, the half-period divider and the format state are internal. When any of them is wrong, the fault shows at the pins within the same word. It appears as a wrong count of `sclk` rising edges, a wrong `frm` low or high width, or a wrong rising-edge spacing. When the receive word is shifted or loaded wrongly, the fault appears in `rxData` the cycle after the word ends: bits are shifted by one, or bits above the size are left non-zero. Gating faults show as `sclk` activity while the port is disabled, misconfigured or has a full receive FIFO, or as a lost or repeated word in the receive order.

// File: rtl/msp_pkg.sv
`timescale 1ns/1ps
package msp_pkg;
  localparam int unsigned WordW   = 16;
  localparam int unsigned CmdBits = 8;
  localparam int unsigned CntW    = 5;
  localparam logic [1:0]  FmtSpi   = 2'b00;
  localparam logic [1:0]  FmtPulse = 2'b01;
  localparam logic [1:0]  FmtMw    = 2'b10;
  localparam logic [1:0]  FmtBad   = 2'b11;
  localparam logic [3:0]  MinSizeCode = 4'd3;

  typedef struct packed {
    logic [7:0] rateDiv;
    logic [3:0] sizeCode;
    logic [1:0] fmt;
    logic       clkSel;
    logic       enable;
  } ctrl_t;

  localparam int unsigned CfgW = $bits(ctrl_t);

  typedef enum logic [2:0] {StIdle, StFrame, StCmd, StTurn, StData} state_e;

  typedef struct packed {
    logic load;
    logic sample;
    logic push;
  } strobe_t;

  function automatic logic [WordW-1:0] sizeMask(input logic [3:0] code);
    logic [WordW:0] t;
    t = ((WordW+1)'(1) << (5'(code) + 5'd1)) - (WordW+1)'(1);
    return t[WordW-1:0];
  endfunction
endpackage

// File: rtl/msp_fifo.sv
`timescale 1ns/1ps
module msp_fifo #(
  parameter int unsigned Width = 16,
  parameter int unsigned Depth = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [Width-1:0] pushData,
  input  logic             pop,
  output logic [Width-1:0] headData,
  output logic             empty,
  output logic             full
);
  localparam int unsigned PtrW = (Depth > 1) ? $clog2(Depth) : 1;
  localparam int unsigned LvlW = $clog2(Depth + 1);

  logic [Width-1:0] mem [Depth];
  logic [PtrW-1:0]  wrPtr, rdPtr;
  logic [LvlW-1:0]  level;
  logic             doPush, doPop;

  assign empty    = (level == '0);
  assign full     = (level == LvlW'(Depth));
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PtrW'(Depth - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PtrW'(Depth - 1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      level <= level + 1'b1;
      else if (doPop && !doPush) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/msp_ctrl.sv
`timescale 1ns/1ps
module msp_ctrl
  import msp_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWe,
  input  logic [CfgW-1:0] cfgWdata,
  input  logic            extClk,
  input  logic            txEmpty,
  input  logic            rxFull,
  output ctrl_t           cfg,
  output strobe_t         stb,
  output state_e          state,
  output logic [CntW-1:0] bitCnt,
  output logic            sclk,
  output logic            frm
);
  logic [2:0]      extSync;
  logic [7:0]      divCnt;
  logic            phase;
  logic            tick, cfgOk, canStart, halfEnd, lastSlot;
  logic [CntW-1:0] lastIdx;
  state_e          stNext, firstState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfg <= '0;
    else if (cfgWe) cfg <= cfgWdata;
  end

  // external source: synchronise and take one tick per rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extSync <= '0;
    else       extSync <= {extSync[1:0], extClk};
  end

  assign tick     = cfg.clkSel ? (extSync[1] & ~extSync[2]) : 1'b1;
  assign cfgOk    = cfg.enable && (cfg.sizeCode >= MinSizeCode) && (cfg.fmt != FmtBad);
  assign canStart = cfgOk && !txEmpty && !rxFull;
  assign halfEnd  = (state != StIdle) && tick && (divCnt == cfg.rateDiv);
  assign lastSlot = halfEnd && phase && (bitCnt == lastIdx);

  always_comb begin
    case (state)
      StCmd:   lastIdx = CntW'(CmdBits - 1);
      StData:  lastIdx = {1'b0, cfg.sizeCode};
      default: lastIdx = '0;
    endcase
  end

  always_comb begin
    case (cfg.fmt)
      FmtPulse: firstState = StFrame;
      FmtMw:    firstState = StCmd;
      default:  firstState = StData;
    endcase
  end

  always_comb begin
    stNext = state;
    stb    = '0;
    if (!cfgOk) begin
      stNext = StIdle;
    end else begin
      case (state)
        StIdle: begin
          if (canStart) begin
            stb.load = 1'b1;
            stNext   = firstState;
          end
        end
        default: begin
          if (halfEnd && !phase && state == StData) stb.sample = 1'b1;
          if (lastSlot) begin
            case (state)
              StFrame: stNext = StData;
              StCmd:   stNext = StTurn;
              StTurn:  stNext = StData;
              default: begin
                stb.push = 1'b1;
                stNext   = StIdle;
              end
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= StIdle;
      phase  <= 1'b0;
      bitCnt <= '0;
      divCnt <= '0;
    end else begin
      state <= stNext;
      if (stNext != state) begin
        phase  <= 1'b0;
        bitCnt <= '0;
        divCnt <= '0;
      end else if (halfEnd) begin
        divCnt <= '0;
        phase  <= ~phase;
        if (phase) bitCnt <= bitCnt + 1'b1;
      end else if (tick && state != StIdle) begin
        divCnt <= divCnt + 8'd1;
      end
    end
  end

  assign sclk = phase;
  assign frm  = (cfg.fmt == FmtPulse) ? (state == StFrame) : (state == StIdle);
endmodule

// File: rtl/msp_datapath.sv
`timescale 1ns/1ps
module msp_datapath
  import msp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  state_e           state,
  input  logic [CntW-1:0]  bitCnt,
  input  logic [1:0]       fmt,
  input  logic [3:0]       sizeCode,
  input  logic [WordW-1:0] txWord,
  input  logic             rxd,
  output logic             txd,
  output logic [WordW-1:0] rxWord
);
  logic [WordW-1:0] holdWord;
  logic [WordW-1:0] rxShift;
  logic [CntW-1:0]  dataIdx, cmdIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
      rxShift  <= '0;
    end else if (stb.load) begin
      holdWord <= txWord;
      rxShift  <= '0;
    end else if (stb.sample) begin
      rxShift <= {rxShift[WordW-2:0], rxd};
    end
  end

  assign dataIdx = CntW'(sizeCode) - bitCnt;
  assign cmdIdx  = CntW'(CmdBits - 1) - bitCnt;

  always_comb begin
    case (state)
      StCmd:   txd = |(holdWord & (WordW'(1) << cmdIdx));
      StData:  txd = (fmt == FmtMw) ? 1'b0 : |(holdWord & (WordW'(1) << dataIdx));
      default: txd = 1'b0;
    endcase
  end

  assign rxWord = rxShift;
endmodule

// File: rtl/multi_serial_port.sv
`timescale 1ns/1ps
module multi_serial_port
  import msp_pkg::*;
#(
  parameter int unsigned FifoDepth = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CfgW-1:0]  cfgWdata,
  output logic [CfgW-1:0]  cfgRdata,
  input  logic             txPush,
  input  logic [WordW-1:0] txData,
  output logic             txFull,
  input  logic             rxPop,
  output logic [WordW-1:0] rxData,
  output logic             rxEmpty,
  input  logic             extClk,
  output logic             sclk,
  output logic             frm,
  output logic             txd,
  input  logic             rxd
);
  ctrl_t            cfg;
  strobe_t          stb;
  state_e           state;
  logic [CntW-1:0]  bitCnt;
  logic             txEmpty, rxFull;
  logic [WordW-1:0] txHead, rxWord;

  assign cfgRdata = cfg;

  msp_fifo #(.Width(WordW), .Depth(FifoDepth)) i_txFifo (
    .clk(clk), .rstN(rstN), .push(txPush), .pushData(txData), .pop(stb.load),
    .headData(txHead), .empty(txEmpty), .full(txFull));

  msp_fifo #(.Width(WordW), .Depth(FifoDepth)) i_rxFifo (
    .clk(clk), .rstN(rstN), .push(stb.push), .pushData(rxWord), .pop(rxPop),
    .headData(rxData), .empty(rxEmpty), .full(rxFull));

  msp_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .extClk(extClk),
    .txEmpty(txEmpty), .rxFull(rxFull), .cfg(cfg), .stb(stb), .state(state),
    .bitCnt(bitCnt), .sclk(sclk), .frm(frm));

  msp_datapath i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .state(state), .bitCnt(bitCnt),
    .fmt(cfg.fmt), .sizeCode(cfg.sizeCode), .txWord(txHead), .rxd(rxd),
    .txd(txd), .rxWord(rxWord));
endmodule

// File: rtl/msp_checker.sv
`timescale 1ns/1ps
module msp_checker
  import msp_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [CfgW-1:0]  cfgWord,
  input strobe_t          stb,
  input logic             txEmpty,
  input logic             rxFull,
  input logic [WordW-1:0] rxWord,
  input logic             sclk,
  input logic             frm
);
  ctrl_t c;
  assign c = cfgWord;

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !c.enable |=> !sclk);

  p_bad_size_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (c.sizeCode < MinSizeCode) |=> !sclk);

  p_bad_fmt_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (c.fmt == FmtBad) |=> !sclk);

  p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> ((rxWord & ~sizeMask(c.sizeCode)) == '0));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> !rxFull);

  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> !txEmpty);

  p_select_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (c.fmt == FmtSpi && frm) |-> !sclk);
endmodule

bind multi_serial_port msp_checker u_check (
  .clk(clk), .rstN(rstN), .cfgWord(cfgRdata), .stb(stb), .txEmpty(txEmpty),
  .rxFull(rxFull), .rxWord(rxWord), .sclk(sclk), .frm(frm));

// File: tb/test_multi_serial_port.sv
`timescale 1ns/1ps
module test_multi_serial_port;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        cfgWe = 1'b0, txPush = 1'b0, rxPop = 1'b0, extClk = 1'b0;
  logic [15:0] cfgWdata = '0, txData = '0;
  logic [15:0] cfgRdata, rxData;
  logic        txFull, rxEmpty, sclk, frm, txd, rxd;

  int checks = 0, errors = 0;
  int cyc = 0, rises = 0, frmHi = 0, frmLo = 0, lastRise = -1, period = 0;
  logic sclkPrev = 1'b0;
  int mwEdges = 0, curN = 4;
  logic [15:0] mwResp = '0;
  logic [7:0]  mwCmdSeen = '0;
  logic        slaveBit = 1'b0, mwMode = 1'b0;

  assign rxd = mwMode ? slaveBit : txd;

  multi_serial_port i_multi_serial_port (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .txPush(txPush), .txData(txData), .txFull(txFull), .rxPop(rxPop), .rxData(rxData),
    .rxEmpty(rxEmpty), .extClk(extClk), .sclk(sclk), .frm(frm), .txd(txd), .rxd(rxd));

  always #2.5 clk = ~clk;

  always begin
    repeat (3) @(negedge clk);
    extClk = ~extClk;
  end

  always @(negedge clk) begin
    cyc++;
    if (sclk && !sclkPrev) begin
      rises++;
      if (lastRise >= 0) period = cyc - lastRise;
      lastRise = cyc;
    end
    sclkPrev = sclk;
    if (frm) frmHi++; else frmLo++;
  end

  // command/response peripheral model
  always @(posedge sclk) begin
    if (mwEdges < 8) mwCmdSeen = {mwCmdSeen[6:0], txd};
    mwEdges++;
  end
  always @(negedge sclk) begin
    if (mwEdges >= 9 && mwEdges < 9 + curN) slaveBit = mwResp[curN - 1 - (mwEdges - 9)];
  end

  function automatic logic [15:0] maskN(input int n);
    return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
  endfunction

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic writeCfg(input logic en, input logic src, input logic [1:0] f,
                          input logic [3:0] code, input logic [7:0] dv);
    @(negedge clk);
    cfgWe = 1'b1; cfgWdata = {dv, code, f, src, en};
    @(negedge clk);
    cfgWe = 1'b0;
    #1;
  endtask

  task automatic clearMon();
    rises = 0; frmHi = 0; frmLo = 0; lastRise = -1; period = 0; mwEdges = 0;
  endtask

  task automatic pushTx(input logic [15:0] w);
    @(negedge clk);
    txPush = 1'b1; txData = w;
    @(negedge clk);
    txPush = 1'b0;
  endtask

  task automatic popRx();
    @(negedge clk);
    rxPop = 1'b1;
    @(negedge clk);
    rxPop = 1'b0;
    #1;
  endtask

  task automatic waitRx(input int limit, input string req);
    int k;
    for (k = 0; k < limit; k++) begin
      @(negedge clk);
      if (!rxEmpty) break;
    end
    #1;
    checkEq(req, "word arrived before timeout", int'(!rxEmpty), 1);
  endtask

  task automatic idleCycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic doWord(input logic [1:0] f, input logic [3:0] code, input logic [7:0] dv,
                        input logic src, input logic [15:0] w, input logic [15:0] resp);
    int n, bitPer;
    logic [15:0] exp;
    n = int'(code) + 1;
    bitPer = 2 * (int'(dv) + 1) * (src ? 6 : 1);
    writeCfg(1'b1, src, f, code, dv);
    clearMon();
    mwResp = resp; curN = n; mwMode = (f == 2'b10);
    pushTx(w);
    waitRx(40000, "R10");
    exp = (f == 2'b10) ? (resp & maskN(n)) : (w & maskN(n));
    checkEq(f == 2'b10 ? "R6" : "R3", "received word", int'(rxData), int'(exp));
    checkEq("R8", "sclk rising-edge spacing", period, bitPer);
    case (f)
      2'b00: begin
        checkEq("R1", "SPI sclk rising edges", rises, n);
        if (!src) checkEq("R4", "SPI select low cycles", frmLo, n * 2 * (int'(dv) + 1));
      end
      2'b01: begin
        checkEq("R5", "frame-pulse sclk rising edges", rises, n + 1);
        if (!src) checkEq("R5", "frame pulse width", frmHi, 2 * (int'(dv) + 1));
      end
      default: begin
        checkEq("R6", "command/response sclk rising edges", rises, n + 9);
        checkEq("R6", "command byte seen", int'(mwCmdSeen), int'(w[7:0]));
        if (!src) checkEq("R6", "select low cycles", frmLo, (n + 9) * 2 * (int'(dv) + 1));
      end
    endcase
    popRx();
    mwMode = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd7741);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    // reset state
    checkEq("R9", "control word after reset", int'(cfgRdata), 0);
    checkEq("R9", "sclk after reset", int'(sclk), 0);
    checkEq("R4", "SPI select idle high", int'(frm), 1);
    checkEq("R11", "rx empty after reset", int'(rxEmpty), 1);
    checkEq("R11", "tx not full after reset", int'(txFull), 0);

    // disabled port does nothing
    writeCfg(1'b0, 1'b0, 2'b00, 4'd7, 8'd0);
    clearMon();
    pushTx(16'h1234);
    idleCycles(200);
    checkEq("R9", "rises while disabled", rises, 0);
    checkEq("R9", "rx empty while disabled", int'(rxEmpty), 1);
    writeCfg(1'b1, 1'b0, 2'b00, 4'd7, 8'd0);
    waitRx(2000, "R9");
    checkEq("R9", "held word after enable", int'(rxData), 16'h0034);
    popRx();

    // reserved size codes
    writeCfg(1'b1, 1'b0, 2'b00, 4'd2, 8'd0);
    clearMon();
    pushTx(16'hBEEF);
    idleCycles(200);
    checkEq("R2", "rises with size code 2", rises, 0);
    writeCfg(1'b1, 1'b0, 2'b00, 4'd0, 8'd0);
    idleCycles(100);
    checkEq("R2", "rises with size code 0", rises, 0);
    checkEq("R2", "rx empty with bad size", int'(rxEmpty), 1);
    writeCfg(1'b1, 1'b0, 2'b00, 4'd7, 8'd0);
    waitRx(2000, "R2");
    checkEq("R2", "held word after valid size", int'(rxData), 16'h00EF);
    popRx();

    // reserved format
    writeCfg(1'b1, 1'b0, 2'b11, 4'd7, 8'd0);
    clearMon();
    pushTx(16'h5A5A);
    idleCycles(200);
    checkEq("R7", "rises with format 11", rises, 0);
    checkEq("R7", "rx empty with format 11", int'(rxEmpty), 1);
    writeCfg(1'b1, 1'b0, 2'b00, 4'd7, 8'd0);
    waitRx(2000, "R7");
    checkEq("R7", "held word after valid format", int'(rxData), 16'h005A);
    popRx();

    // directed corners
    doWord(2'b00, 4'd3,  8'd0, 1'b0, 16'hFFFF, 16'h0);
    doWord(2'b00, 4'd15, 8'd2, 1'b0, 16'hA5C3, 16'h0);
    doWord(2'b01, 4'd3,  8'd1, 1'b0, 16'hFFF9, 16'h0);
    doWord(2'b01, 4'd15, 8'd0, 1'b0, 16'h8001, 16'h0);
    doWord(2'b10, 4'd11, 8'd0, 1'b0, 16'h00C6, 16'hF9A5);
    doWord(2'b10, 4'd15, 8'd1, 1'b0, 16'h0081, 16'h8003);
    doWord(2'b00, 4'd7,  8'd1, 1'b1, 16'h00B4, 16'h0);
    doWord(2'b10, 4'd4,  8'd0, 1'b1, 16'h0055, 16'h0013);

    // frame-pulse words back to back
    writeCfg(1'b1, 1'b0, 2'b01, 4'd5, 8'd0);
    clearMon();
    pushTx(16'h002A);
    pushTx(16'h0015);
    idleCycles(300);
    checkEq("R5", "rises for two queued words", rises, 14);
    checkEq("R5", "first queued word", int'(rxData), 16'h002A);
    popRx();
    checkEq("R5", "second queued word", int'(rxData), 16'h0015);
    popRx();

    // receive FIFO full holds the port
    writeCfg(1'b1, 1'b0, 2'b00, 4'd3, 8'd0);
    clearMon();
    for (int i = 0; i < 5; i++) pushTx(16'(16'h0A0 + i));
    idleCycles(600);
    checkEq("R10", "rises with rx full", rises, 16);
    popRx();
    idleCycles(200);
    checkEq("R10", "rises after room freed", rises, 20);
    for (int i = 1; i < 5; i++) begin
      checkEq("R10", "rx order after full", int'(rxData), int'(16'h0A0 + i) & 16'hF);
      popRx();
    end
    checkEq("R10", "one entry per word", int'(rxEmpty), 1);

    // transmit FIFO overflow is dropped
    writeCfg(1'b0, 1'b0, 2'b00, 4'd7, 8'd0);
    for (int i = 0; i < 6; i++) pushTx(16'(16'h31 + i));
    checkEq("R11", "tx full after 6 pushes", int'(txFull), 1);
    popRx();
    checkEq("R11", "pop of empty rx ignored", int'(rxEmpty), 1);
    writeCfg(1'b1, 1'b0, 2'b00, 4'd7, 8'd0);
    idleCycles(500);
    for (int i = 0; i < 4; i++) begin
      checkEq("R11", "kept tx word order", int'(rxData), 16'h31 + i);
      popRx();
    end
    checkEq("R11", "overflow words dropped", int'(rxEmpty), 1);

    // constrained random
    for (int i = 0; i < 30; i++) begin
      logic [1:0] f;
      logic [3:0] code;
      f    = 2'($urandom_range(0, 2));
      code = 4'($urandom_range(3, 15));
      doWord(f, code, 8'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
             16'($urandom), 16'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule